// File: doc/BRIEF.md
# Bus Read Handshake Controller

This block sequences a read transfer between a bus master and a local device whose data reaches the bus through a transceiver. The bus side is one four-phase handshake: the master raises a read request and waits for an acknowledge. The device side is a second four-phase handshake: the controller raises a strobe and the device answers with its own acknowledge. The controller ties the two together in a fixed order. It strobes the device, opens the transceiver once the device answers, and acknowledges the bus one cycle later. When the master withdraws its request, the controller closes the transceiver first and then drops the bus acknowledge and the device strobe together.

The device may still be returning its acknowledge to low when the next bus request arrives. The controller accepts that request, but it does not strobe the device again until the device acknowledge has been seen low. The write request input is part of the interface but has no effect. All three inputs pass through synchronizers, and every output is a flop of the state register, so the outputs cannot glitch.

Top module: `bus_rd_hsk`

## Requirements
- R1: While reset is asserted, whether at power-up or in the middle of a transfer, dev_strobe, xcvr_en and bus_ack are all 0. Reset assertion clears them at once, without waiting for a clock.
- R2: In idle with dev_ack low, a rise of bus_rd_req sets dev_strobe on the third rising clock edge after the change. Each input passes two synchronizer flops and then the state flop. The other outputs stay 0.
- R3: xcvr_en rises only after dev_ack has been seen high. It rises three edges after dev_ack rises, and it stays 0 for as long as the device keeps dev_ack low.
- R4: bus_ack rises exactly one edge after xcvr_en rises. It then holds at 1, with dev_strobe and xcvr_en also at 1, for as long as bus_rd_req stays high.
- R5: A fall of bus_rd_req clears xcvr_en three edges later, while bus_ack and dev_strobe are still 1.
- R6: One edge after xcvr_en falls, bus_ack and dev_strobe fall together.
- R7: A new bus_rd_req rise while dev_ack is still high leaves all outputs 0. dev_strobe rises three edges after dev_ack falls. This also holds when the request rise and the dev_ack fall happen in the same cycle.
- R8: bus_wr_req has no effect. When it is held high in idle, all outputs stay 0. When it is high during a read, the read follows the same timing as without it.
- R9: The output triple {dev_strobe, xcvr_en, bus_ack} only takes the values 000, 100, 110, 111 and 101. Neither xcvr_en nor bus_ack is ever 1 while dev_strobe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset. Assertion is asynchronous; release passes through a synchronizer |
| bus_rd_req | input | 1 | Read request from the bus master (asynchronous) |
| bus_wr_req | input | 1 | Write request from the bus master (asynchronous, ignored) |
| dev_ack | input | 1 | Acknowledge from the local device (asynchronous) |
| dev_strobe | output | 1 | Strobe to the local device |
| xcvr_en | output | 1 | Output enable for the data transceiver |
| bus_ack | output | 1 | Data acknowledge to the bus master |

## Verification
The device-side release and the next bus-side request can coincide. The device can drop dev_ack in the same cycle that the master raises a fresh bus_rd_req. The bench provokes this by driving both edges on one falling clock edge, directly after a transfer has ended with dev_ack still high. It expects dev_strobe on exactly the third following edge, and no earlier output activity. A second scenario holds dev_ack high for many cycles under a pending request and confirms that the outputs stay at 000 until the release.

// File: rtl/bus_rd_hsk_pkg.sv
package bus_rd_hsk_pkg;

  // State code doubles as the output vector {strobe, enable, ack}
  localparam int unsigned OUT_W = 3;

  typedef enum logic [OUT_W-1:0] {
    ST_IDLE   = 3'b000,
    ST_STROBE = 3'b100,
    ST_ENABLE = 3'b110,
    ST_ACKED  = 3'b111,
    ST_DROP   = 3'b101
  } hsk_state_e;

  localparam int unsigned BIT_STROBE = 2;
  localparam int unsigned BIT_ENABLE = 1;
  localparam int unsigned BIT_ACK    = 0;

endpackage

// File: rtl/bus_rd_hsk_rst_sync.sv
module bus_rd_hsk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/bus_rd_hsk_sync.sv
module bus_rd_hsk_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= '0;
        end else begin
          if (g == 0) begin
            stage_q[g] <= async_i;
          end else begin
            stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
          end
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/bus_rd_hsk_fsm.sv
module bus_rd_hsk_fsm
  import bus_rd_hsk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_s,
  input  logic wr_s,
  input  logic ack_s,
  output logic strobe_o,
  output logic enable_o,
  output logic ack_o
);

  hsk_state_e state_q;
  hsk_state_e state_nx;
  logic       state_en;

  // Next-state process
  always_comb begin
    state_nx = state_q;
    case (state_q)
      ST_IDLE: begin
        // device must have released its acknowledge before a new strobe
        if (rd_s && !ack_s) state_nx = ST_STROBE;
      end
      ST_STROBE: begin
        if (ack_s) state_nx = ST_ENABLE;
      end
      ST_ENABLE: begin
        state_nx = ST_ACKED;
      end
      ST_ACKED: begin
        if (!rd_s) state_nx = ST_DROP;
      end
      ST_DROP: begin
        state_nx = ST_IDLE;
      end
      default: begin
        state_nx = ST_IDLE;
      end
    endcase
  end

  assign state_en = (state_nx != state_q);

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (state_en) begin
      state_q <= state_nx;
    end
  end

  assign strobe_o = state_q[BIT_STROBE];
  assign enable_o = state_q[BIT_ENABLE];
  assign ack_o    = state_q[BIT_ACK];

  // R2: a strobe only follows a seen read request
  a_r2_strobe_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_o) |-> $past(rd_s));

  // R3: transceiver opens only after the device acknowledged
  a_r3_enable_after_dev_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable_o) |-> $past(ack_s));

  // R4: bus acknowledge follows an already open transceiver
  a_r4_ack_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> ($past(enable_o) && enable_o));

  // R5: transceiver closes on a withdrawn request with bus ack still high
  a_r5_enable_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(enable_o) |-> (!$past(rd_s) && ack_o && strobe_o));

  // R6: bus ack and device strobe fall together, transceiver already closed
  a_r6_joint_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> ($fell(strobe_o) && !enable_o));

  // R7: no new strobe while the device acknowledge is still high
  a_r7_wait_dev_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_o) |-> !$past(ack_s));

  // R8: a write request alone never leaves idle
  a_r8_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !rd_s && wr_s) |=> (state_q == ST_IDLE));

  // R9: enable and ack only ever appear under the strobe
  a_r9_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_o || ack_o) |-> strobe_o);

endmodule

// File: rtl/bus_rd_hsk.sv
module bus_rd_hsk #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rd_req,
  input  logic bus_wr_req,
  input  logic dev_ack,
  output logic dev_strobe,
  output logic xcvr_en,
  output logic bus_ack
);

  localparam int unsigned IN_W = 3;

  logic            rst_int_n;
  logic [IN_W-1:0] in_async;
  logic [IN_W-1:0] in_sync;

  bus_rd_hsk_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign in_async = {bus_rd_req, bus_wr_req, dev_ack};

  bus_rd_hsk_sync #(
    .WIDTH  (IN_W),
    .STAGES (SYNC_STAGES)
  ) u_in_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i (in_async),
    .sync_o  (in_sync)
  );

  bus_rd_hsk_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_s     (in_sync[2]),
    .wr_s     (in_sync[1]),
    .ack_s    (in_sync[0]),
    .strobe_o (dev_strobe),
    .enable_o (xcvr_en),
    .ack_o    (bus_ack)
  );

endmodule

// File: tb/bus_rd_hsk_bench.sv
module bus_rd_hsk_bench;

  logic clk = 1'b0;
  logic rst_n;
  logic rd, wr, dack;
  logic strobe, en, back;
  int   n_chk  = 0;
  int   n_fail = 0;
  int   cyc    = 0;
  logic mon_on = 1'b0;

  always #4 clk = ~clk;

  bus_rd_hsk u_bus_rd_hsk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd_req (rd),
    .bus_wr_req (wr),
    .dev_ack    (dack),
    .dev_strobe (strobe),
    .xcvr_en    (en),
    .bus_ack    (back)
  );

  wire [2:0] obs = {strobe, en, back};

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: cycles %0d expected below 100000", cyc);
      summary();
      $finish;
    end
  end

  // R9: legal output code in every sampled cycle
  always @(negedge clk) begin
    if (mon_on) begin
      n_chk++;
      if (!(obs inside {3'b000, 3'b100, 3'b110, 3'b111, 3'b101})) begin
        n_fail++;
        $display("FAIL R9: outputs %b expected a legal code", obs);
      end
    end
  end

  task automatic chk(input logic [2:0] exp, input string tag);
    n_chk++;
    if (obs !== exp) begin
      n_fail++;
      $display("FAIL %s: {strobe,en,ack}=%b expected %b", tag, obs, exp);
    end
  endtask

  task automatic step_chk(input logic [2:0] exp, input string tag);
    @(negedge clk);
    chk(exp, tag);
  endtask

  // From a pending strobe (obs 100): device answers, master withdraws.
  // Ends with obs 000 and dev_ack still high.
  task automatic finish_from_strobe(input string tag);
    dack = 1'b1;
    step_chk(3'b100, {tag, " R3 wait"});
    step_chk(3'b100, {tag, " R3 wait"});
    step_chk(3'b110, {tag, " R3 enable"});
    step_chk(3'b111, {tag, " R4 ack"});
    rd = 1'b0;
    step_chk(3'b111, {tag, " R5 hold"});
    step_chk(3'b111, {tag, " R5 hold"});
    step_chk(3'b101, {tag, " R5 enable drop"});
    step_chk(3'b000, {tag, " R6 release"});
  endtask

  task automatic read_cycle(input string tag);
    rd = 1'b1;
    step_chk(3'b000, {tag, " R2 latency"});
    step_chk(3'b000, {tag, " R2 latency"});
    step_chk(3'b100, {tag, " R2 strobe"});
    finish_from_strobe(tag);
  endtask

  task automatic settle();
    dack = 1'b0;
    rd   = 1'b0;
    for (int i = 0; i < 4; i++) step_chk(3'b000, "idle R8");
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rd = 1'b0; wr = 1'b0; dack = 1'b0;
    repeat (3) @(negedge clk);
    chk(3'b000, "R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(3'b000, "R1 after release");
    mon_on = 1'b1;
  endtask

  task automatic t_basic();
    read_cycle("basic");
    settle();
  endtask

  task automatic t_write_ignored();
    wr = 1'b1;
    for (int i = 0; i < 8; i++) step_chk(3'b000, "R8 write in idle");
    read_cycle("R8 write during read");
    wr = 1'b0;
    settle();
  endtask

  task automatic t_slow_device();
    rd = 1'b1;
    step_chk(3'b000, "slow R2");
    step_chk(3'b000, "slow R2");
    step_chk(3'b100, "slow R2 strobe");
    for (int i = 0; i < 20; i++) step_chk(3'b100, "R3 no enable without dev_ack");
    finish_from_strobe("slow");
    settle();
  endtask

  task automatic t_long_hold();
    rd = 1'b1;
    repeat (3) @(negedge clk);
    dack = 1'b1;
    repeat (4) @(negedge clk);
    chk(3'b111, "R4 reached ack");
    for (int i = 0; i < 12; i++) step_chk(3'b111, "R4 hold while request high");
    rd = 1'b0;
    step_chk(3'b111, "R5 hold");
    step_chk(3'b111, "R5 hold");
    step_chk(3'b101, "R5 enable drop");
    step_chk(3'b000, "R6 release");
    settle();
  endtask

  task automatic t_overlap();
    read_cycle("ovl first");
    rd = 1'b1;
    for (int i = 0; i < 8; i++) step_chk(3'b000, "R7 no strobe while dev_ack high");
    dack = 1'b0;
    step_chk(3'b000, "R7 latency");
    step_chk(3'b000, "R7 latency");
    step_chk(3'b100, "R7 strobe after release");
    finish_from_strobe("ovl second");
    settle();
  endtask

  task automatic t_same_cycle();
    read_cycle("same first");
    rd   = 1'b1;
    dack = 1'b0;
    step_chk(3'b000, "R7 same-cycle latency");
    step_chk(3'b000, "R7 same-cycle latency");
    step_chk(3'b100, "R7 same-cycle strobe");
    finish_from_strobe("same second");
    settle();
  endtask

  task automatic t_reset_mid();
    rd = 1'b1;
    repeat (3) @(negedge clk);
    dack = 1'b1;
    repeat (4) @(negedge clk);
    chk(3'b111, "R1 reached ack before reset");
    rst_n = 1'b0;
    #1;
    chk(3'b000, "R1 async clear");
    rd = 1'b0; dack = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(3'b000, "R1 after mid reset");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_write_ignored();
    t_slow_device();
    t_long_hold();
    t_overlap();
    t_same_cycle();
    mon_on = 1'b0;
    t_reset_mid();
    summary();
    $finish;
  end

endmodule